// File: doc/BRIEF.md
# Programmable Chopper Clock Generator

The block derives two chopper clocks from a 16.384 MHz system clock. The fast output takes a 2-bit select. It can rest high, toggle at 512 kHz or 256 kHz, or pass the system clock through a registered enable. The slow output takes a 4-bit select. It can rest high, rest low, or toggle at 1000/(2n) Hz, where n is the select value from 1 to 14. Those rates are counted in ticks of an internal 1 kHz prescaler, which divides the system clock by `TICK_DIV` (16384 by default).

The selects arrive as plain input buses and may change at any time. While an output toggles, a new select is taken only when that output is about to rise, so the period in progress always completes and no runt pulse appears. While an output rests at a constant level, a new select is taken on the next clock edge. An active-low asynchronous reset returns both selects to their resting-high defaults.

Top module: `chop_clk_gen`

## Requirements
- R1: During and right after reset both outputs are high.
- R2: With fast select 00 the fast output stays high.
- R3: With fast select 01 the fast output is high for `FAST_HALF_A` (16) clocks and then low for the same count, which gives 512 kHz.
- R4: With fast select 10 the fast output is high and then low for `FAST_HALF_B` (32) clocks each, which gives 256 kHz.
- R5: With fast select 11 the fast output follows the system clock: high in its high phase, low in its low phase.
- R6: With slow select 0000 the slow output stays high.
- R7: With slow select 1111 the slow output stays low.
- R8: With slow select n in 1..14 the slow output is high for n*`TICK_DIV` clocks and then low for n*`TICK_DIV` clocks.
- R9: While the slow output toggles, a new select waits for the next rising edge of that output. The high and low halves in progress complete at the old rate.
- R10: From a resting select, a new toggling select takes effect within two clocks, starting with a high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fast_sel | input | 2 | Fast output mode: 00 high, 01 512 kHz, 10 256 kHz, 11 system clock |
| slow_sel | input | 4 | Slow output mode: 0000 high, 1111 low, n gives 1000/(2n) Hz |
| fast_clk_o | output | 1 | Fast chopper clock |
| slow_clk_o | output | 1 | Slow chopper clock |

## Verification
Each toggling code is run with an enlarged prescaler until several full halves have passed. Each half is measured in half-clock samples and compared with the length that code should give. The lengths 1, 32 and 64 separate the pass-through mode from the two divided fast rates. The slow codes 1, 5 and 14 show that the divide factor scales with n and does not saturate. The resting codes are sampled over long windows. A select change made in the middle of a slow high half is followed at chosen offsets from that half's rising edge. These samples show that the old high and low halves both complete before the new, shorter period begins. A switch out of the resting-low state must show a high level within two clocks.

// File: rtl/chop_clk_pkg.sv
package chop_clk_pkg;
   localparam int SLOW_W = 4;
   localparam int FAST_W = 2;

   typedef logic [SLOW_W-1:0] slow_code_t;

   typedef enum logic [FAST_W-1:0] {
      FAST_HOLD_HI = 2'b00,
      FAST_RATE_A  = 2'b01,
      FAST_RATE_B  = 2'b10,
      FAST_PASS    = 2'b11
   } fast_mode_e;

   localparam slow_code_t SLOW_HOLD_HI = 4'h0;
   localparam slow_code_t SLOW_HOLD_LO = 4'hF;

   function automatic logic slow_is_const(slow_code_t c);
      return (c == SLOW_HOLD_HI) || (c == SLOW_HOLD_LO);
   endfunction

   function automatic logic slow_start_lvl(slow_code_t c);
      return c != SLOW_HOLD_LO;
   endfunction
endpackage

// File: rtl/chop_tick_gen.sv
module chop_tick_gen #(
   parameter int TICK_DIV = 16384
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("TICK_DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == LAST);
endmodule

// File: rtl/chop_slow_chan.sv
module chop_slow_chan
   import chop_clk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  slow_code_t sel,
   output logic       lvl_o
);
   slow_code_t act_q;
   slow_code_t cnt_q;
   logic       lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= SLOW_HOLD_HI;
         cnt_q <= '0;
         lvl_q <= 1'b1;
      end else if (slow_is_const(act_q)) begin
         // resting: any new code is taken at once
         act_q <= sel;
         cnt_q <= '0;
         lvl_q <= slow_start_lvl(sel);
      end else if (tick) begin
         if (cnt_q == act_q - 1'b1) begin
            cnt_q <= '0;
            if (lvl_q) begin
               lvl_q <= 1'b0;
            end else begin
               // rising boundary: the only point where a toggling code changes
               act_q <= sel;
               lvl_q <= slow_start_lvl(sel);
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign lvl_o = lvl_q;
endmodule

// File: rtl/chop_fast_chan.sv
module chop_fast_chan
   import chop_clk_pkg::*;
#(
   parameter int FAST_HALF_A = 16,
   parameter int FAST_HALF_B = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FAST_W-1:0] sel,
   output logic             clk_o
);
   localparam int HMAX = (FAST_HALF_A > FAST_HALF_B) ? FAST_HALF_A : FAST_HALF_B;
   localparam int CW   = (HMAX > 1) ? $clog2(HMAX) : 1;
   localparam logic [CW-1:0] LAST_A = CW'(FAST_HALF_A - 1);
   localparam logic [CW-1:0] LAST_B = CW'(FAST_HALF_B - 1);

   generate
      if (FAST_HALF_A < 2 || FAST_HALF_B < 2) begin : g_bad_half
         $error("fast half periods must be at least 2 clocks");
      end
   endgenerate

   fast_mode_e    act_q;
   logic [CW-1:0] cnt_q;
   logic          div_q;
   logic          gate_q;
   logic [CW-1:0] last;

   always_comb begin
      last = (act_q == FAST_RATE_A) ? LAST_A : LAST_B;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= FAST_HOLD_HI;
         cnt_q <= '0;
         div_q <= 1'b1;
      end else if (act_q == FAST_HOLD_HI || act_q == FAST_PASS) begin
         // every edge is a boundary in these modes
         act_q <= fast_mode_e'(sel);
         cnt_q <= '0;
         div_q <= (fast_mode_e'(sel) != FAST_PASS);
      end else if (cnt_q == last) begin
         cnt_q <= '0;
         if (div_q) begin
            div_q <= 1'b0;
         end else begin
            act_q <= fast_mode_e'(sel);
            div_q <= (fast_mode_e'(sel) != FAST_PASS);
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // enable moves only while clk is low, so the gated clock cannot glitch
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= (act_q == FAST_PASS);
   end

   assign clk_o = (clk & gate_q) | (div_q & ~gate_q);
endmodule

// File: rtl/chop_clk_gen.sv
module chop_clk_gen #(
   parameter int TICK_DIV    = 16384,
   parameter int FAST_HALF_A = 16,
   parameter int FAST_HALF_B = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] fast_sel,
   input  logic [3:0] slow_sel,
   output logic       fast_clk_o,
   output logic       slow_clk_o
);
   logic tick_w;

   chop_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_w)
   );

   chop_slow_chan u_slow (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_w),
      .sel   (slow_sel),
      .lvl_o (slow_clk_o)
   );

   chop_fast_chan #(
      .FAST_HALF_A (FAST_HALF_A),
      .FAST_HALF_B (FAST_HALF_B)
   ) u_fast (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (fast_sel),
      .clk_o (fast_clk_o)
   );
endmodule

// File: rtl/chop_clk_gen_chk.sv
module chop_clk_gen_chk #(
   parameter int CW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    fast_sel,
   input logic [3:0]    slow_sel,
   input logic          slow_clk_o,
   input logic          tick,
   input logic [3:0]    slow_act,
   input logic [1:0]    fast_act,
   input logic          fast_gate,
   input logic          fast_div,
   input logic [CW-1:0] fast_cnt,
   input logic [CW-1:0] fast_last
);
   assert_gate_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fast_gate == (fast_act == 2'b11));

   assert_fast_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_act == 2'b00 && fast_sel == 2'b00) |=> (fast_div && fast_act == 2'b00));

   assert_fast_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_act == 2'b01 || fast_act == 2'b10) |-> (fast_cnt <= fast_last));

   assert_slow_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_act == 4'h0 && slow_sel == 4'h0) |=> slow_clk_o);

   assert_slow_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_act == 4'hF && slow_sel == 4'hF) |=> !slow_clk_o);

   assert_slow_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && slow_act != 4'h0 && slow_act != 4'hF)
         |=> ($stable(slow_clk_o) && $stable(slow_act)));
endmodule

bind chop_clk_gen chop_clk_gen_chk #(
   .CW ((((FAST_HALF_A > FAST_HALF_B) ? FAST_HALF_A : FAST_HALF_B) > 1) ?
        $clog2((FAST_HALF_A > FAST_HALF_B) ? FAST_HALF_A : FAST_HALF_B) : 1)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fast_sel   (fast_sel),
   .slow_sel   (slow_sel),
   .slow_clk_o (slow_clk_o),
   .tick       (tick_w),
   .slow_act   (u_slow.act_q),
   .fast_act   (u_fast.act_q),
   .fast_gate  (u_fast.gate_q),
   .fast_div   (u_fast.div_q),
   .fast_cnt   (u_fast.cnt_q),
   .fast_last  (u_fast.last)
);

// File: tb/sim_chop_clk_gen.sv
module sim_chop_clk_gen;
   localparam int CLK_PER = 64;
   localparam int TDIV    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] fast_sel = 2'b00;
   logic [3:0] slow_sel = 4'h0;
   logic       fast_clk_o;
   logic       slow_clk_o;

   int    n_chk = 0;
   int    n_fail = 0;
   int    exp_q[$];
   string cur_tag = "";
   int    mon_ch = 0;
   bit    mon_arm = 0;
   bit    mon_skip = 0;
   int    run_len = 0;
   logic  prev_v = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   chop_clk_gen #(.TICK_DIV(TDIV), .FAST_HALF_A(16), .FAST_HALF_B(32)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .fast_sel   (fast_sel),
      .slow_sel   (slow_sel),
      .fast_clk_o (fast_clk_o),
      .slow_clk_o (slow_clk_o)
   );

   function automatic logic cur_out();
      return (mon_ch == 0) ? fast_clk_o : slow_clk_o;
   endfunction

   // monitor: run-length encodes the chosen output and pops expected run lengths
   task automatic take_sample();
      logic v;
      int   e;
      if (!mon_arm) return;
      v = cur_out();
      if (v == prev_v) begin
         run_len++;
      end else begin
         if (mon_skip) begin
            mon_skip = 0;
         end else if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if (run_len != e) begin
               n_fail++;
               $display("FAIL %s: run length %0d, expected %0d", cur_tag, run_len, e);
            end
         end
         prev_v  = v;
         run_len = 1;
      end
   endtask

   always @(posedge clk) begin #(CLK_PER/4); take_sample(); end
   always @(negedge clk) begin #(CLK_PER/4); take_sample(); end

   task automatic check_bit(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b, expected %b", tag, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #(CLK_PER/8);
   endtask

   // driver: applies a code, waits out the switch, queues expected half lengths
   task automatic scb_run(int ch, logic [3:0] code, int exp_len, int nruns,
                          string tag, int settle);
      bit done;
      step(1);
      mon_arm = 0;
      if (ch == 0) fast_sel = code[1:0];
      else         slow_sel = code;
      step(settle);
      exp_q.delete();
      cur_tag  = tag;
      mon_ch   = ch;
      prev_v   = cur_out();
      run_len  = 0;
      mon_skip = 1;
      for (int i = 0; i < nruns; i++) exp_q.push_back(exp_len);
      mon_arm = 1;
      done = 0;
      for (int c = 0; c < (nruns + 3) * (exp_len + 1) && !done; c++) begin
         @(posedge clk);
         if (exp_q.size() == 0) done = 1;
      end
      #(CLK_PER/8);
      mon_arm = 0;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL %s: %0d halves not seen, expected 0 left", tag, exp_q.size());
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int t;
      step(3);
      check_bit("R1 fast in reset", fast_clk_o, 1'b1);
      check_bit("R1 slow in reset", slow_clk_o, 1'b1);
      rst_n = 1'b1;
      step(2);
      check_bit("R1 fast after reset", fast_clk_o, 1'b1);
      check_bit("R1 slow after reset", slow_clk_o, 1'b1);

      // R2 / R6: resting high over a long window, both clock phases
      for (int i = 0; i < 40; i++) begin
         step(1);
         check_bit("R2 fast hold", fast_clk_o, 1'b1);
         check_bit("R6 slow hold", slow_clk_o, 1'b1);
         #(CLK_PER/2);
         check_bit("R2 fast hold low phase", fast_clk_o, 1'b1);
      end

      // fast divided rates and pass-through (lengths in half-clock samples)
      scb_run(0, 4'h1, 32, 4, "R3 fast 512k", 140);
      scb_run(0, 4'h2, 64, 4, "R4 fast 256k", 140);
      scb_run(0, 4'h3, 1, 10, "R5 fast pass", 140);
      scb_run(0, 4'h1, 32, 2, "R3 fast back from pass", 20);
      fast_sel = 2'b00;
      step(140);
      for (int i = 0; i < 20; i++) begin
         step(1);
         check_bit("R2 fast rest again", fast_clk_o, 1'b1);
      end

      // slow rates: n*TDIV clocks per half, two samples per clock
      scb_run(1, 4'h1, 2 * 1 * TDIV, 3, "R8 slow n=1", 300);
      scb_run(1, 4'h5, 2 * 5 * TDIV, 3, "R8 slow n=5", 300);
      scb_run(1, 4'hE, 2 * 14 * TDIV, 3, "R8 slow n=14", 300);

      slow_sel = 4'hF;
      step(300);
      for (int i = 0; i < 50; i++) begin
         step(1);
         check_bit("R7 slow rest low", slow_clk_o, 1'b0);
      end

      // R10: leaving resting-low starts high within two clocks
      slow_sel = 4'h3;
      step(2);
      check_bit("R10 leave rest", slow_clk_o, 1'b1);

      // R9: change in mid high half; old halves of 3*TDIV complete first
      step(200);
      t = 0;
      while (slow_clk_o !== 1'b0 && t < 200) begin step(1); t++; end
      while (slow_clk_o !== 1'b1 && t < 400) begin step(1); t++; end
      step(8);
      slow_sel = 4'h1;
      step(12);
      check_bit("R9 old high kept at +20", slow_clk_o, 1'b1);
      step(10);
      check_bit("R9 old low at +30", slow_clk_o, 1'b0);
      step(16);
      check_bit("R9 old low kept at +46", slow_clk_o, 1'b0);
      step(4);
      check_bit("R9 rise at boundary +50", slow_clk_o, 1'b1);
      step(10);
      check_bit("R9 new rate low at +60", slow_clk_o, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule